// File: doc/BRIEF.md
# Clock-Compensated Beep Tone Generator

This block makes a square-wave audio tone from a free-running counter that advances once every two system clocks. Software picks the pitch by setting one bit in a tap field of a 32-bit configuration word. Each field bit stands for one counter bit, and the chosen counter bit drives the tone output. A separate one-bit enable in an 8-bit control word gates the output.

The system clock can be slowed to one half or one thirty-second of its full rate. The block is told the current divider setting, and it moves its tap to a lower counter bit on its own, so the pitch in wall-clock time stays about the same. Software does not need to rewrite the tap field when the clock changes. Writes come through a simple one-cycle write port with a one-bit register address.

Top module: `beep_tone_gen`

## Requirements
- R1: The counter starts at zero when reset is released and advances by one every second clock, so a steady tap at counter bit t toggles the output every 2^(t+1) clocks.
- R2: Address 0 is the control word. Its bit 0 is the enable, and while the enable is clear the output is held low. Bits 7:1 of a control write are ignored.
- R3: Address 1 is the tap word. Bits FIELD_LSB+FIELD_W-1 down to FIELD_LSB (18:10 by default) form the tap field, and at full rate field bit k selects counter bit FIELD_LSB+k. All other bits of a tap write are ignored.
- R4: When more than one field bit is set, the lowest set bit decides the tap.
- R5: When the tap field is zero, the output is held low.
- R6: The divider input is encoded 2'b00 full rate, 2'b01 half rate, 2'b10 one thirty-second rate, and 2'b11 is treated as full rate. The tap moves down by HALF_SHIFT (1) at half rate and by SLOW_SHIFT (5) at one thirty-second rate, and it saturates at counter bit 0.
- R7: Reset clears the enable and the tap field, and it drives the output low.

Top module parameters: CNT_W, FIELD_LSB, FIELD_W, DATA_W, HALF_SHIFT, SLOW_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one clock |
| cfg_addr | input | 1 | Register address: 0 for the control word, 1 for the tap word |
| cfg_wdata | input | DATA_W | Write data |
| clk_div_sel | input | 2 | Current system clock divider setting |
| tone_out | output | 1 | Registered square-wave tone |

## Verification
The assertions assume that reset is held low for at least two clock edges, so every `$past` value comes from reset state. They also assume that the write port and the divider input change only synchronously to the clock, and that the tap field fits inside the counter. The bench holds reset for four cycles and drives every input on the falling edge. It uses a small configuration whose counter and field are narrow enough to sweep every field bit under every divider code, including the reserved one. Before it times any tone, it skips two output edges after each write or divider change, so the output has moved off the old tap.

// File: rtl/beep_pkg.sv
// Shared types and helpers for the beep tone generator.
// Assumes: callers pass shift amounts that are non-negative.
package beep_pkg;

    // System clock divider setting reported by the clock-change logic.
    typedef enum logic [1:0] {
        DIV_FULL = 2'b00,
        DIV_HALF = 2'b01,
        DIV_SLOW = 2'b10,
        DIV_RSVD = 2'b11
    } div_mode_e;

    // Register addresses on the write port.
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_TAP  = 1'b1;

    // Number of counter bits by which the tap moves down for a divider mode.
    function automatic int rate_shift(input div_mode_e mode,
                                      input int half_sh,
                                      input int slow_sh);
        case (mode)
            DIV_HALF: return half_sh;
            DIV_SLOW: return slow_sh;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/beep_counter.sv
// Free-running counter that advances once every two clocks.
// Assumes: rst_n is synchronous and held for at least two edges.
module beep_counter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);

    logic             phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase flop: splits the system clock into alternate advance slots.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Counter register: advances only in the slot the phase flop marks.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (phase_q) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R1: every change of the counter is a step of exactly one.
    p_step_by_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R1: the counter never advances in two adjacent cycles.
    p_half_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |=> $stable(cnt_q));

endmodule

// File: rtl/beep_regs.sv
// Configuration registers: the enable in the control word and the tap field
// in the tap word. Reserved bits of the write data are dropped.
// Assumes: the field lies inside the data word.
module beep_regs
    import beep_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 10,
    parameter int FIELD_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               en_o,
    output logic [FIELD_W-1:0] field_o
);

    logic               en_q;
    logic [FIELD_W-1:0] field_q;
    logic               unused_wdata;

    // Reserved data bits are read nowhere else; fold them here.
    assign unused_wdata = ^wdata;

    // Enable register: loaded from bit 0 of a control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= 1'b0;
        else if (we && addr == ADDR_CTRL) en_q <= wdata[0];
    end

    // Tap field register: loaded from the field slice of a tap-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      field_q <= '0;
        else if (we && addr == ADDR_TAP) field_q <= wdata[FIELD_LSB +: FIELD_W];
    end

    assign en_o    = en_q;
    assign field_o = field_q;

    // R2: the enable moves only on a control-word write.
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADDR_CTRL) |=> $stable(en_q));

    // R3: the tap field moves only on a tap-word write.
    p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADDR_TAP) |=> $stable(field_q));

endmodule

// File: rtl/beep_tap_sel.sv
// Turns the tap field and the divider mode into a counter bit index.
// The lowest set field bit wins. The index moves down by the rate shift
// and stops at zero.
// Assumes: FIELD_LSB + FIELD_W <= CNT_W.
module beep_tap_sel
    import beep_pkg::*;
#(
    parameter int CNT_W      = 19,
    parameter int FIELD_LSB  = 10,
    parameter int FIELD_W    = 9,
    parameter int HALF_SHIFT = 1,
    parameter int SLOW_SHIFT = 5,
    localparam int IDX_W     = $clog2(CNT_W)
) (
    input  logic [FIELD_W-1:0] field_i,
    input  div_mode_e          mode_i,
    output logic [IDX_W-1:0]   tap_idx_o,
    output logic               tap_valid_o
);

    int pos_full;
    int shift_amt;
    int pos_eff;

    // Priority pick: scan from the top so the lowest set bit is kept last.
    always_comb begin
        pos_full    = FIELD_LSB;
        tap_valid_o = 1'b0;
        for (int k = FIELD_W - 1; k >= 0; k--) begin
            if (field_i[k]) begin
                pos_full    = FIELD_LSB + k;
                tap_valid_o = 1'b1;
            end
        end
    end

    // Rate compensation: move the tap down by the divider shift and stop at zero.
    always_comb begin
        shift_amt = rate_shift(mode_i, HALF_SHIFT, SLOW_SHIFT);
        if (pos_full >= shift_amt) pos_eff = pos_full - shift_amt;
        else                       pos_eff = 0;
        tap_idx_o = IDX_W'(pos_eff);
    end

endmodule

// File: rtl/beep_tone_gen.sv
// Top of the beep tone generator. It ties the counter, the configuration
// registers and the tap selector together and registers the tone output.
// Assumes: all inputs are synchronous to clk.
module beep_tone_gen
    import beep_pkg::*;
#(
    parameter int CNT_W      = 19,
    parameter int FIELD_LSB  = 10,
    parameter int FIELD_W    = 9,
    parameter int DATA_W     = 32,
    parameter int HALF_SHIFT = 1,
    parameter int SLOW_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        clk_div_sel,
    output logic              tone_out
);

    localparam int IDX_W = $clog2(CNT_W);

    logic [CNT_W-1:0]   cnt;
    logic               en;
    logic [FIELD_W-1:0] field;
    logic [IDX_W-1:0]   tap_idx;
    logic               tap_valid;
    logic               tone_q;
    div_mode_e          mode;

    assign mode = div_mode_e'(clk_div_sel);

    beep_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    beep_regs #(
        .DATA_W    (DATA_W),
        .FIELD_LSB (FIELD_LSB),
        .FIELD_W   (FIELD_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .en_o    (en),
        .field_o (field)
    );

    beep_tap_sel #(
        .CNT_W      (CNT_W),
        .FIELD_LSB  (FIELD_LSB),
        .FIELD_W    (FIELD_W),
        .HALF_SHIFT (HALF_SHIFT),
        .SLOW_SHIFT (SLOW_SHIFT)
    ) u_tap (
        .field_i     (field),
        .mode_i      (mode),
        .tap_idx_o   (tap_idx),
        .tap_valid_o (tap_valid)
    );

    // Output flop: copies the chosen counter bit while enabled and tapped.
    always_ff @(posedge clk) begin
        if (!rst_n) tone_q <= 1'b0;
        else        tone_q <= en & tap_valid & cnt[tap_idx];
    end

    assign tone_out = tone_q;

    // R7: a cycle in reset leaves the output low.
    p_reset_low_r7: assert property (@(posedge clk)
        !rst_n |=> !tone_out);

    // R2: a clear enable forces the output low on the next cycle.
    p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tone_out);

    // R5: an empty tap field forces the output low on the next cycle.
    p_silent_empty_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (field == '0) |=> !tone_out);

    // R6: the compensated tap always names a real counter bit.
    p_tap_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_idx) < CNT_W);

endmodule

// File: tb/beep_tone_gen_tb.sv
// Bench: narrow configuration, every field bit swept under every divider code.
module beep_tone_gen_tb;

    localparam int CNT_W  = 9;
    localparam int LSB    = 4;
    localparam int FW     = 5;
    localparam int DW     = 32;
    localparam int LIMIT  = 4 * (1 << (CNT_W + 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [1:0]    clk_div_sel = 2'b00;
    logic          tone_out;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    beep_tone_gen #(
        .CNT_W(CNT_W), .FIELD_LSB(LSB), .FIELD_W(FW), .DATA_W(DW),
        .HALF_SHIFT(1), .SLOW_SHIFT(5)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .clk_div_sel(clk_div_sel), .tone_out(tone_out)
    );

    task automatic write_reg(input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic expect_eq(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait for one output edge and return the cycles it took.
    task automatic edge_wait(output int n);
        logic prev;
        prev = tone_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tone_out == prev && n < LIMIT);
    endtask

    // Skip two edges, then time two half periods against the expectation.
    task automatic measure(input int exp, input string tag);
        int n;
        edge_wait(n);
        edge_wait(n);
        edge_wait(n);
        expect_eq(n, exp, tag);
        edge_wait(n);
        expect_eq(n, exp, tag);
    endtask

    // Count high samples over a window; a silent output gives zero.
    task automatic check_silent(input int window, input string tag);
        int highs = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (tone_out) highs++;
        end
        expect_eq(highs, 0, tag);
    endtask

    function automatic int exp_half(input int k, input int mode);
        int sh;
        int t;
        sh = (mode == 1) ? 1 : (mode == 2) ? 5 : 0;
        t = (LSB + k >= sh) ? LSB + k - sh : 0;
        return 2 << t;
    endfunction

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7: output low straight after reset and while nothing is configured.
        expect_eq(int'(tone_out), 0, "R7 reset output");
        check_silent(64, "R7 idle after reset");

        // R2: reserved control bits alone do not enable the tone.
        write_reg(1'b1, 32'(1) << (LSB + 2));
        write_reg(1'b0, 32'h0000_00FE);
        check_silent(600, "R2 reserved control bits");

        // R2: enable in bit 0 starts the tone (tap LSB+2 full rate).
        write_reg(1'b0, 32'h0000_0001);
        measure(exp_half(2, 0), "R2 enabled tone");

        // R1 R3 R6: every field bit under every divider code.
        for (int m = 0; m < 4; m++) begin
            clk_div_sel = 2'(m);
            for (int k = 0; k < FW; k++) begin
                write_reg(1'b1, 32'(1) << (LSB + k));
                measure(exp_half(k, m), $sformatf("R1 R3 R6 mode=%0d bit=%0d", m, k));
            end
        end
        clk_div_sel = 2'b00;

        // R3: reserved tap-word bits around the field are ignored.
        write_reg(1'b1, (32'(1) << (LSB + 2)) | ~(32'h1F << LSB));
        measure(exp_half(2, 0), "R3 reserved tap bits");

        // R4: several set bits, lowest wins (bits 1 and 3).
        write_reg(1'b1, 32'h0A << LSB);
        measure(exp_half(1, 0), "R4 lowest bit full rate");
        clk_div_sel = 2'b10;
        write_reg(1'b1, 32'h14 << LSB);
        measure(exp_half(2, 2), "R4 lowest bit slow rate");

        // R6: a divider change alone moves the tap, no rewrite.
        clk_div_sel = 2'b01;
        measure(exp_half(2, 1), "R6 divider change half");
        clk_div_sel = 2'b00;
        measure(exp_half(2, 0), "R6 divider change back to full");

        // R5: empty field and reserved-only tap word keep the output low.
        write_reg(1'b1, 32'h0);
        check_silent(600, "R5 empty field");
        write_reg(1'b1, ~(32'h1F << LSB));
        check_silent(600, "R5 reserved-only tap word");

        // R2: clearing the enable silences a running tone.
        write_reg(1'b1, 32'(1) << LSB);
        write_reg(1'b0, 32'h0000_0000);
        check_silent(600, "R2 enable cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule